// File: doc/BRIEF.md
# Tag Coprocessor Decoupling Queue with System-Call Synchronization

This block sits between a main processor core and an off-core tag-checking coprocessor. For every instruction the core commits, it hands over a record carrying the program counter, the instruction encoding and the physical address of the memory access. The record goes into a shallow first-in first-out queue. The coprocessor drains that queue at its own rate through a ready/valid port and reports security exceptions back. The core only waits when the queue has no room.

The two sides run out of step with each other. They come back into step only at a system call. While the core holds its system-call request, the block stalls it until every earlier record has left the queue and the coprocessor is idle. If the coprocessor has flagged an exception by then, the stall stays up and the trap output tells the core to trap rather than execute the call. The trap output also holds the program counter of the offending record until software acknowledges it.

Top module: `tagcop_sync_queue`

## Requirements
- R1: After reset the queue is empty (`cop_valid_o` low), `core_stall_o` is low and `trap_o` is low.
- R2: Records reach the coprocessor port in commit order, each with its PC, encoding and address unchanged, with no record lost or repeated.
- R3: The queue holds `DEPTH` (default 6) records. When it is full and `cop_ready_i` is low, a commit raises `core_stall_o` and is not taken; the queued records stay intact.
- R4: A commit offered while the queue is full and the coprocessor pops in the same cycle does not raise `core_stall_o`; both transfers happen.
- R5: While `syscall_i` is high, `core_stall_o` stays high as long as the queue holds a record or `cop_busy_i` is high.
- R6: With `syscall_i` high, `core_stall_o` falls one cycle after the first cycle in which the queue is empty, `cop_busy_i` is low, no exception arrives and no trap is pending.
- R7: A `cop_exc_i` pulse raises `trap_o` on the next cycle with `trap_pc_o` set to `cop_exc_pc_i`. Both hold until `trap_ack_i`. Later exceptions while the trap is held do not change `trap_pc_o`.
- R8: While `trap_o` is high, a system call stays stalled.
- R9: An exception arriving in the same cycle as `trap_ack_i` replaces the held trap: `trap_o` stays high with the new PC.
- R10: An exception arriving in the same cycle that the queue drains at a system call prevents the release; the core stays stalled with `trap_o` raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| commit_valid_i | input | 1 | Core offers a committed-instruction record |
| commit_pc_i | input | PC_W | PC of the committed instruction |
| commit_insn_i | input | INSN_W | Instruction encoding |
| commit_paddr_i | input | PA_W | Physical address of the access |
| syscall_i | input | 1 | Core is waiting at a system call |
| core_stall_o | output | 1 | Core must hold (queue full or sync pending) |
| trap_o | output | 1 | Security trap pending for the core |
| trap_pc_o | output | PC_W | PC of the offending record |
| trap_ack_i | input | 1 | Software acknowledges the trap |
| cop_valid_o | output | 1 | Head record available to the coprocessor |
| cop_pc_o | output | PC_W | Head record PC |
| cop_insn_o | output | INSN_W | Head record encoding |
| cop_paddr_o | output | PA_W | Head record address |
| cop_ready_i | input | 1 | Coprocessor takes the head record |
| cop_busy_i | input | 1 | Coprocessor still checking a popped record |
| cop_exc_i | input | 1 | Coprocessor reports a security exception |
| cop_exc_pc_i | input | PC_W | PC of the record that caused it |

## Verification
Two pairs of events are made to land in the same cycle. The first is a commit and a pop on a full queue: the queue is filled with the consumer held off, the commit is left hanging and shown to be stalled, then ready is raised under it and the stall must drop while the head advances. The second is an exception and the queue draining at a system call: one record is queued, the system call is raised with ready high, and the exception is driven in the very cycle the queue becomes empty. The bench requires the stall to stay up and the trap to carry that record's PC. A design that checked only the registered trap would release the core one cycle too early.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic {
    SYNC_HOLD  = 1'b0,
    SYNC_CLEAR = 1'b1
  } sync_st_e;

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/tsq_fifo.sv
module tsq_fifo #(
  parameter int unsigned W     = 96,
  parameter int unsigned DEPTH = 6,
  localparam int unsigned PTR_W = tsq_pkg::ptr_bits(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     data_i,
  output logic [W-1:0]     data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign cnt_o   = cnt_q;
  assign data_o  = mem_q[rd_ptr_q];

  logic do_push, do_pop;
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem_q[g] <= '0;
      else if (do_push && wr_ptr_q == PTR_W'(g))       mem_q[g] <= data_i;
    end
  end
endmodule

// File: rtl/tsq_exc_latch.sv
module tsq_exc_latch #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exc_i,
  input  logic [PC_W-1:0] exc_pc_i,
  input  logic            ack_i,
  output logic            trap_o,
  output logic [PC_W-1:0] trap_pc_o
);
  logic            trap_q;
  logic [PC_W-1:0] pc_q;

  // a fresh exception wins over an acknowledge in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q <= 1'b0;
      pc_q   <= '0;
    end else if (exc_i && (!trap_q || ack_i)) begin
      trap_q <= 1'b1;
      pc_q   <= exc_pc_i;
    end else if (ack_i) begin
      trap_q <= 1'b0;
    end
  end

  assign trap_o    = trap_q;
  assign trap_pc_o = pc_q;
endmodule

// File: rtl/tsq_sync_ctrl.sv
module tsq_sync_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic syscall_i,
  input  logic drained_i,
  input  logic exc_seen_i,
  output logic hold_o
);
  import tsq_pkg::*;

  sync_st_e st_q, st_d;

  // recomputed every cycle: release only after a full cycle of clean state
  always_comb begin
    st_d = SYNC_HOLD;
    if (syscall_i && drained_i && !exc_seen_i) st_d = SYNC_CLEAR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SYNC_HOLD;
    else         st_q <= st_d;
  end

  assign hold_o = syscall_i && (st_q != SYNC_CLEAR);
endmodule

// File: rtl/tagcop_sync_queue.sv
module tagcop_sync_queue #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned DEPTH  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_valid_i,
  input  logic [PC_W-1:0]   commit_pc_i,
  input  logic [INSN_W-1:0] commit_insn_i,
  input  logic [PA_W-1:0]   commit_paddr_i,
  input  logic              syscall_i,
  output logic              core_stall_o,
  output logic              trap_o,
  output logic [PC_W-1:0]   trap_pc_o,
  input  logic              trap_ack_i,
  output logic              cop_valid_o,
  output logic [PC_W-1:0]   cop_pc_o,
  output logic [INSN_W-1:0] cop_insn_o,
  output logic [PA_W-1:0]   cop_paddr_o,
  input  logic              cop_ready_i,
  input  logic              cop_busy_i,
  input  logic              cop_exc_i,
  input  logic [PC_W-1:0]   cop_exc_pc_i
);
  localparam int unsigned REC_W = PC_W + INSN_W + PA_W;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [REC_W-1:0] rec_in, rec_out;
  logic             q_empty, q_full, q_push, q_pop, full_stall, sync_hold;
  logic [CNT_W-1:0] fill_cnt;

  assign rec_in     = {commit_pc_i, commit_insn_i, commit_paddr_i};
  assign q_pop      = !q_empty && cop_ready_i;
  // a pop in the same cycle frees the slot the commit needs
  assign full_stall = commit_valid_i && q_full && !cop_ready_i;
  assign q_push     = commit_valid_i && !full_stall;

  tsq_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (q_push),
    .pop_i   (q_pop),
    .data_i  (rec_in),
    .data_o  (rec_out),
    .empty_o (q_empty),
    .full_o  (q_full),
    .cnt_o   (fill_cnt)
  );

  tsq_exc_latch #(.PC_W(PC_W)) u_exc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exc_i     (cop_exc_i),
    .exc_pc_i  (cop_exc_pc_i),
    .ack_i     (trap_ack_i),
    .trap_o    (trap_o),
    .trap_pc_o (trap_pc_o)
  );

  tsq_sync_ctrl u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .syscall_i  (syscall_i),
    .drained_i  (q_empty && !cop_busy_i),
    .exc_seen_i (trap_o || cop_exc_i),
    .hold_o     (sync_hold)
  );

  assign core_stall_o = full_stall || sync_hold;
  assign cop_valid_o  = !q_empty;
  assign {cop_pc_o, cop_insn_o, cop_paddr_o} = rec_out;
endmodule

// File: rtl/tagcop_sync_queue_chk.sv
module tagcop_sync_queue_chk #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned DEPTH = 6,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             commit_valid_i,
  input logic             syscall_i,
  input logic             cop_ready_i,
  input logic             cop_busy_i,
  input logic             cop_exc_i,
  input logic             trap_ack_i,
  input logic             core_stall_o,
  input logic             trap_o,
  input logic [PC_W-1:0]  trap_pc_o,
  input logic [CNT_W-1:0] fill_i
);
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= CNT_W'(DEPTH));

  assert_full_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i == CNT_W'(DEPTH) && !cop_ready_i) |=> (fill_i == CNT_W'(DEPTH)));

  assert_pass_through_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_i && cop_ready_i && !syscall_i) |-> !core_stall_o);

  assert_release_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syscall_i && !core_stall_o) |->
      $past(fill_i == '0 && !cop_busy_i && !cop_exc_i && !trap_o));

  assert_trap_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !trap_ack_i) |=> (trap_o && $stable(trap_pc_o)));

  assert_trap_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trap_o) |-> $past(cop_exc_i));

  assert_trap_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syscall_i && trap_o) |-> core_stall_o);
endmodule

bind tagcop_sync_queue tagcop_sync_queue_chk #(.PC_W(PC_W), .DEPTH(DEPTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .commit_valid_i (commit_valid_i),
  .syscall_i      (syscall_i),
  .cop_ready_i    (cop_ready_i),
  .cop_busy_i     (cop_busy_i),
  .cop_exc_i      (cop_exc_i),
  .trap_ack_i     (trap_ack_i),
  .core_stall_o   (core_stall_o),
  .trap_o         (trap_o),
  .trap_pc_o      (trap_pc_o),
  .fill_i         (fill_cnt)
);

// File: tb/tagcop_sync_queue_bench.sv
module tagcop_sync_queue_bench;
  localparam int unsigned PW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic commit_valid_i = 1'b0;
  logic [PW-1:0] commit_pc_i = '0, commit_insn_i = '0, commit_paddr_i = '0;
  logic syscall_i = 1'b0, trap_ack_i = 1'b0;
  logic cop_ready_i = 1'b0, cop_busy_i = 1'b0, cop_exc_i = 1'b0;
  logic [PW-1:0] cop_exc_pc_i = '0;
  logic core_stall_o, trap_o, cop_valid_o;
  logic [PW-1:0] trap_pc_o, cop_pc_o, cop_insn_o, cop_paddr_o;

  always #2 clk_i = ~clk_i;

  tagcop_sync_queue u_tagcop_sync_queue (
    .clk_i, .rst_ni, .commit_valid_i, .commit_pc_i, .commit_insn_i, .commit_paddr_i,
    .syscall_i, .core_stall_o, .trap_o, .trap_pc_o, .trap_ack_i,
    .cop_valid_o, .cop_pc_o, .cop_insn_o, .cop_paddr_o,
    .cop_ready_i, .cop_busy_i, .cop_exc_i, .cop_exc_pc_i
  );

  int n_tests = 0, n_fail = 0, n_pops = 0;
  logic [95:0] sbq [$];

  function automatic logic [95:0] rec(input int i);
    return {32'h0000_1000 + 32'(4 * i), 32'hA500_0000 | 32'(i), 32'h8000_0000 + 32'(16 * i)};
  endfunction

  task automatic check(input string req, input string what, input logic [95:0] act, input logic [95:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  // driver: offer a record until taken; scoreboard gets it when accepted
  task automatic commit(input int i);
    logic [95:0] r;
    r = rec(i);
    commit_valid_i = 1'b1;
    {commit_pc_i, commit_insn_i, commit_paddr_i} = r;
    forever begin
      @(negedge clk_i);
      if (!core_stall_o) begin
        sbq.push_back(r);
        step();
        break;
      end
      step();
    end
    commit_valid_i = 1'b0;
  endtask

  task automatic drain();
    cop_ready_i = 1'b1;
    forever begin
      @(negedge clk_i);
      if (!cop_valid_o) break;
    end
    step();
  endtask

  // monitor: every transfer must match the oldest expected record (R2)
  always @(negedge clk_i) begin
    if (rst_ni && cop_valid_o && cop_ready_i) begin
      n_pops++;
      if (sbq.size() == 0) check("R2", "unexpected record", {cop_pc_o, cop_insn_o, cop_paddr_o}, '0);
      else check("R2", "record order", {cop_pc_o, cop_insn_o, cop_paddr_o}, sbq.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk_i);
    check("R1", "cop_valid in reset", 96'(cop_valid_o), 96'(0));
    check("R1", "stall in reset", 96'(core_stall_o), 96'(0));
    check("R1", "trap in reset", 96'(trap_o), 96'(0));
    step(); rst_ni = 1'b1; step();
    check("R1", "cop_valid after reset", 96'(cop_valid_o), 96'(0));

    // fill, overflow attempt, then push+pop on full (R3, R4)
    base = n_pops;
    cop_ready_i = 1'b0;
    for (int i = 0; i < 6; i++) commit(i);
    commit_valid_i = 1'b1;
    {commit_pc_i, commit_insn_i, commit_paddr_i} = rec(6);
    @(negedge clk_i);
    check("R3", "stall when full", 96'(core_stall_o), 96'(1));
    step();
    @(negedge clk_i);
    check("R3", "still stalled", 96'(core_stall_o), 96'(1));
    check("R3", "head intact", 96'(cop_pc_o), 96'(rec(0) >> 64));
    step();
    cop_ready_i = 1'b1;
    @(negedge clk_i);
    check("R4", "no stall on push+pop", 96'(core_stall_o), 96'(0));
    sbq.push_back(rec(6));
    step();
    commit_valid_i = 1'b0; cop_ready_i = 1'b0;
    @(negedge clk_i);
    check("R4", "head advanced", 96'(cop_pc_o), 96'(rec(1) >> 64));
    step();
    drain();
    check("R2", "seven records out", 96'(n_pops - base), 96'(7));

    // streaming with ready toggling (R2)
    for (int i = 8; i < 20; i++) begin
      cop_ready_i = i[0];
      commit(i);
    end
    drain();
    check("R2", "scoreboard empty", 96'(sbq.size()), 96'(0));

    // system call sync (R5, R6)
    cop_ready_i = 1'b0;
    commit(20); commit(21);
    cop_busy_i = 1'b1; syscall_i = 1'b1;
    @(negedge clk_i);
    check("R5", "stall with records queued", 96'(core_stall_o), 96'(1));
    step();
    drain();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check("R5", "stall while busy", 96'(core_stall_o), 96'(1));
      step();
    end
    cop_busy_i = 1'b0;
    @(negedge clk_i);
    check("R6", "no release in idle cycle", 96'(core_stall_o), 96'(1));
    step();
    @(negedge clk_i);
    check("R6", "release next cycle", 96'(core_stall_o), 96'(0));
    step();
    syscall_i = 1'b0; cop_ready_i = 1'b0;

    // exception latch and trap blocking (R7, R8)
    cop_exc_i = 1'b1; cop_exc_pc_i = 32'hDEAD_0010;
    step();
    cop_exc_pc_i = 32'hBEEF_0020;
    @(negedge clk_i);
    check("R7", "trap raised", 96'(trap_o), 96'(1));
    check("R7", "trap pc", 96'(trap_pc_o), 96'(32'hDEAD_0010));
    step();
    cop_exc_i = 1'b0;
    @(negedge clk_i);
    check("R7", "later exception ignored", 96'(trap_pc_o), 96'(32'hDEAD_0010));
    step();
    syscall_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check("R8", "stall while trap", 96'(core_stall_o), 96'(1));
      step();
    end
    trap_ack_i = 1'b1;
    step();
    trap_ack_i = 1'b0;
    @(negedge clk_i);
    check("R7", "trap cleared by ack", 96'(trap_o), 96'(0));
    check("R6", "stall one more cycle", 96'(core_stall_o), 96'(1));
    step();
    @(negedge clk_i);
    check("R6", "released after ack", 96'(core_stall_o), 96'(0));
    step();
    syscall_i = 1'b0;

    // ack and new exception together (R9)
    cop_exc_i = 1'b1; cop_exc_pc_i = 32'h0000_C0C0;
    step();
    cop_exc_pc_i = 32'h0000_D0D0; trap_ack_i = 1'b1;
    step();
    cop_exc_i = 1'b0; trap_ack_i = 1'b0;
    @(negedge clk_i);
    check("R9", "trap kept", 96'(trap_o), 96'(1));
    check("R9", "new pc", 96'(trap_pc_o), 96'(32'h0000_D0D0));
    step();
    trap_ack_i = 1'b1;
    step();
    trap_ack_i = 1'b0;
    @(negedge clk_i);
    check("R9", "cleared", 96'(trap_o), 96'(0));
    step();

    // exception in the cycle the queue drains at a syscall (R10)
    cop_ready_i = 1'b0;
    commit(30);
    syscall_i = 1'b1; cop_ready_i = 1'b1;
    step();
    cop_ready_i = 1'b0; cop_exc_i = 1'b1; cop_exc_pc_i = rec(30)[95:64];
    step();
    cop_exc_i = 1'b0;
    @(negedge clk_i);
    check("R10", "trap on drain", 96'(trap_o), 96'(1));
    check("R10", "trap pc of record", 96'(trap_pc_o), 96'(rec(30) >> 64));
    check("R10", "stall held", 96'(core_stall_o), 96'(1));
    step();
    @(negedge clk_i);
    check("R10", "stall still held", 96'(core_stall_o), 96'(1));
    step();
    trap_ack_i = 1'b1;
    step();
    trap_ack_i = 1'b0; syscall_i = 1'b0;
    step();
    check("R2", "final scoreboard empty", 96'(sbq.size()), 96'(0));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule